// File: doc/BRIEF.md
# RAS-only Refresh Controller

This block keeps a DRAM array alive by visiting one row per refresh interval. A free-running timer counts clock cycles. At the end of each interval it adds one refresh to a backlog. When the backlog is non-zero, the controller asks the processor for the bus by raising a hold request. It stays off the shared lines until the processor grants the bus.

Once granted, the controller enables its drivers and pulls the active-low read indicator low, so the cycle runs in the read state. It puts its refresh row counter on the row address lines. After one setup cycle it pulls RAS# low for a programmed number of cycles. The column strobe is never used, because this is a RAS-only refresh.

After each strobe, RAS# stays high for a programmed precharge time, the backlog drops by one and the row counter steps. If refreshes are still owed, the next one follows inside the same bus tenure. Otherwise the hold request is withdrawn. The controller then waits for the grant to drop before it may request again.

Top module: `dref_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `hold_o` is 0, `addr_oe_o` is 0, `ras_n_o` is 1 and `mrd_n_o` is 1.
- R2: The timer produces one refresh trigger every `INTERVAL` clock cycles. When each grant comes at once, successive rising edges of `hold_o` are exactly `INTERVAL` cycles apart.
- R3: While `hold_o` is 1 and `hlda_i` has not yet been seen at 1, `addr_oe_o` stays 0, `mrd_n_o` stays 1 and `ras_n_o` stays 1.
- R4: From the first cycle after the grant is seen until `hold_o` falls, `addr_oe_o` is 1 and `mrd_n_o` is 0. `ras_n_o` is 0 only inside that window.
- R5: Each RAS# low pulse lasts exactly `RAS_LOW` cycles. `row_addr_o` holds the current refresh row for the whole pulse.
- R6: After each RAS# rising edge, RAS# stays high for at least `PRECHG` cycles before the next low pulse, and before `hold_o` falls.
- R7: After a refresh tenure, `hold_o` falls and `addr_oe_o` goes to 0. No new hold request is raised while `hlda_i` is still 1, even if a trigger has arrived in the meantime.
- R8: The row counter starts at 0 and increases by one per RAS# pulse. After row 2^`ROW_W`-1 it wraps to 0.
- R9: Triggers that arrive while a refresh is pending or running are counted, up to 2^`PEND_W`-1 of them. All counted refreshes run back to back in one bus tenure before `hold_o` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hlda_i | input | 1 | Bus grant from the processor |
| hold_o | output | 1 | Bus request to the processor |
| mrd_n_o | output | 1 | Memory-read indicator, active low |
| row_addr_o | output | ROW_W | Refresh row address |
| addr_oe_o | output | 1 | Drive enable for the address lines and the read indicator |
| ras_n_o | output | 1 | Row strobe, active low |

## Verification
The bench holds the grant back for many cycles. A controller that drove the lines early, or strobed RAS# before the grant, would show an enable or a low strobe during that wait.

It also holds the grant back past a second trigger. A design that dropped triggers would give one pulse instead of two in that tenure.

It keeps the grant high past a later trigger after the request falls. A design that did not wait for the grant to drop would raise `hold_o` again during that window.

It runs the row counter through its wrap and times each strobe and each gap. An off-by-one in the phase counter, or in the row step, would show as a wrong pulse length, a short precharge or a wrong row.

// File: rtl/dref_pkg.sv
package dref_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_SETUP,
        ST_STROBE,
        ST_PRECH,
        ST_NEXT,
        ST_REL
    } dref_state_e;

    typedef struct packed {
        logic hold;
        logic drive;
        logic strobe;
    } dref_ctl_t;

    function automatic dref_ctl_t dref_decode(dref_state_e s);
        dref_ctl_t c;
        c.hold   = (s == ST_REQ) || (s == ST_SETUP) || (s == ST_STROBE) ||
                   (s == ST_PRECH) || (s == ST_NEXT);
        c.drive  = (s == ST_SETUP) || (s == ST_STROBE) ||
                   (s == ST_PRECH) || (s == ST_NEXT);
        c.strobe = (s == ST_STROBE);
        return c;
    endfunction

    function automatic int dref_max(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dref_timer.sv
module dref_timer #(
    parameter int INTERVAL = 1_500_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

    logic [TW-1:0] cnt;

    assign tick_o = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick_o) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o); // R2

endmodule

// File: rtl/dref_backlog.sv
module dref_backlog #(
    parameter int PEND_W = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic done_i,
    output logic owed_o
);
    localparam logic [PEND_W-1:0] FULL = '1;

    logic [PEND_W-1:0] cnt;

    assign owed_o = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            case ({tick_i, done_i})
                2'b10:   cnt <= (cnt == FULL) ? cnt : cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (done_i && !tick_i) |-> (cnt != '0)); // R9
    AST_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (cnt == FULL && tick_i && !done_i) |=> (cnt == FULL)); // R9

endmodule

// File: rtl/dref_seq.sv
module dref_seq
    import dref_pkg::*;
#(
    parameter int ROW_W   = 10,
    parameter int RAS_LOW = 4,
    parameter int PRECHG  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hlda_i,
    input  logic             owed_i,
    output logic             done_o,
    output logic             hold_o,
    output logic             addr_oe_o,
    output logic             mrd_n_o,
    output logic             ras_n_o,
    output logic [ROW_W-1:0] row_o
);
    localparam int PH_MAX = dref_max(RAS_LOW, PRECHG);
    localparam int PH_W   = (PH_MAX > 1) ? $clog2(PH_MAX) : 1;
    localparam logic [PH_W-1:0] LOW_LOAD = PH_W'(RAS_LOW - 1);
    localparam logic [PH_W-1:0] PRE_LOAD = PH_W'(PRECHG - 1);

    dref_state_e     state, nxt;
    logic [PH_W-1:0] ph, ph_nxt;
    dref_ctl_t       ctl;

    assign ctl       = dref_decode(state);
    assign hold_o    = ctl.hold;
    assign addr_oe_o = ctl.drive;
    assign mrd_n_o   = !ctl.drive;
    assign ras_n_o   = !ctl.strobe;
    assign done_o    = (state == ST_PRECH) && (ph == '0);

    always_comb begin
        nxt    = state;
        ph_nxt = ph;
        case (state)
            ST_IDLE:  if (owed_i) nxt = ST_REQ;
            ST_REQ:   if (hlda_i) nxt = ST_SETUP;
            ST_SETUP: begin
                nxt    = ST_STROBE;
                ph_nxt = LOW_LOAD;
            end
            ST_STROBE: begin
                if (ph == '0) begin
                    nxt    = ST_PRECH;
                    ph_nxt = PRE_LOAD;
                end else begin
                    ph_nxt = ph - 1'b1;
                end
            end
            ST_PRECH: begin
                if (ph == '0) nxt = ST_NEXT;
                else          ph_nxt = ph - 1'b1;
            end
            ST_NEXT:  nxt = owed_i ? ST_SETUP : ST_REL;
            ST_REL:   if (!hlda_i) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ph    <= '0;
            row_o <= '0;
        end else begin
            state <= nxt;
            ph    <= ph_nxt;
            if (done_o) row_o <= row_o + 1'b1;
        end
    end

    AST_GRANT_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_oe_o) |-> $past(hlda_i)); // R3
    AST_STROBE_IN_READ: assert property (@(posedge clk) disable iff (rst)
        !ras_n_o |-> (addr_oe_o && !mrd_n_o && hold_o)); // R4
    AST_ROW_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!ras_n_o && $past(!ras_n_o)) |-> $stable(row_o)); // R5
    AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (row_o == ROW_W'($past(row_o) + 1'b1))); // R8
    AST_RELEASE_WAITS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REL && hlda_i) |=> !hold_o); // R7

endmodule

// File: rtl/dref_ctrl.sv
module dref_ctrl #(
    parameter int INTERVAL = 1_500_000,
    parameter int ROW_W    = 10,
    parameter int RAS_LOW  = 4,
    parameter int PRECHG   = 3,
    parameter int PEND_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hlda_i,
    output logic             hold_o,
    output logic             mrd_n_o,
    output logic [ROW_W-1:0] row_addr_o,
    output logic             addr_oe_o,
    output logic             ras_n_o
);
    logic tick, owed, done;

    dref_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    dref_backlog #(.PEND_W(PEND_W)) u_backlog (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick),
        .done_i (done),
        .owed_o (owed)
    );

    dref_seq #(
        .ROW_W   (ROW_W),
        .RAS_LOW (RAS_LOW),
        .PRECHG  (PRECHG)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .hlda_i    (hlda_i),
        .owed_i    (owed),
        .done_o    (done),
        .hold_o    (hold_o),
        .addr_oe_o (addr_oe_o),
        .mrd_n_o   (mrd_n_o),
        .ras_n_o   (ras_n_o),
        .row_o     (row_addr_o)
    );

    AST_IDLE_OFF_BUS: assert property (@(posedge clk) disable iff (rst)
        !hold_o |-> (!addr_oe_o && ras_n_o && mrd_n_o)); // R7

endmodule

// File: tb/dref_ctrl_test.sv
module dref_ctrl_test;
    localparam int INTERVAL = 60;
    localparam int ROW_W    = 3;
    localparam int RAS_LOW  = 3;
    localparam int PRECHG   = 2;
    localparam int PEND_W   = 3;
    localparam int ROWS     = 1 << ROW_W;

    logic             clk = 0;
    logic             rst = 1;
    logic             hlda = 0;
    logic             hold, mrd_n, oe, ras_n;
    logic [ROW_W-1:0] row;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int exp_row = 0;
    int last_rise = -1;
    int total_pulses = 0;
    bit finished = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dref_ctrl #(
        .INTERVAL (INTERVAL),
        .ROW_W    (ROW_W),
        .RAS_LOW  (RAS_LOW),
        .PRECHG   (PRECHG),
        .PEND_W   (PEND_W)
    ) uut (
        .clk        (clk),
        .rst        (rst),
        .hlda_i     (hlda),
        .hold_o     (hold),
        .mrd_n_o    (mrd_n),
        .row_addr_o (row),
        .addr_oe_o  (oe),
        .ras_n_o    (ras_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wait_hold(output bit seen);
        seen = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (hold) begin
                seen = 1;
                break;
            end
        end
        chk(seen, "R2 hold request", int'(seen), 1);
    endtask

    // One refresh tenure: grant after 'delay' cycles, count pulses, hold grant 'linger' cycles after release
    task automatic round(input int delay, input int exp_pulses, input int linger, input string req);
        bit seen, in_low, any;
        int low_len, high_len, pulses;
        wait_hold(seen);
        if (!seen) return;
        last_rise = cyc;
        for (int i = 0; i < delay; i++) begin
            chk(hold && !oe && ras_n && mrd_n, "R3 no drive before grant", int'(oe), 0);
            @(negedge clk);
        end
        hlda = 1;
        in_low = 0; any = 0; low_len = 0; high_len = 0; pulses = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!hold) break;
            chk(oe && !mrd_n, "R4 drive and read during tenure", int'(oe), 1);
            if (!ras_n) begin
                if (!in_low) begin
                    pulses++;
                    if (any) chk(high_len >= PRECHG, "R6 precharge between pulses", high_len, PRECHG);
                    chk(int'(row) == exp_row, "R5/R8 row address", int'(row), exp_row);
                end
                in_low = 1;
                low_len++;
            end else begin
                if (in_low) begin
                    chk(low_len == RAS_LOW, "R5 RAS low width", low_len, RAS_LOW);
                    if (exp_row == ROWS - 1) chk(1'b1, "R8 wrap reached", 0, 0);
                    exp_row = (exp_row + 1) % ROWS;
                    total_pulses++;
                    in_low = 0; low_len = 0; high_len = 0; any = 1;
                end
                high_len++;
            end
        end
        chk(high_len >= PRECHG, "R6 precharge before release", high_len, PRECHG);
        chk(pulses == exp_pulses, req, pulses, exp_pulses);
        for (int i = 0; i < linger; i++) begin
            chk(!hold && !oe && ras_n && mrd_n, "R7 off bus while grant lingers", int'(hold), 0);
            @(negedge clk);
        end
        hlda = 0;
    endtask

    task automatic test_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        chk(!hold && !oe && ras_n && mrd_n, "R1 outputs in reset", int'(hold), 0);
        rst = 0;
        @(negedge clk);
        chk(!hold && !oe && ras_n && mrd_n, "R1 outputs after reset", int'(oe), 0);
    endtask

    task automatic test_interval();
        int prev;
        round(0, 1, 1, "R2 single pulse per trigger");
        prev = last_rise;
        for (int k = 0; k < 3; k++) begin
            round(0, 1, 1, "R2 single pulse per trigger");
            chk(last_rise - prev == INTERVAL, "R2 trigger period", last_rise - prev, INTERVAL);
            prev = last_rise;
        end
    endtask

    task automatic test_late_grant();
        round(20, 1, 1, "R3 late grant single pulse");
    endtask

    task automatic test_backlog();
        round(80, 2, 1, "R9 two owed refreshes back to back");
    endtask

    task automatic test_linger();
        // grant stays high across a trigger; request must wait for its fall
        round(0, 1, 70, "R7 pulse before linger");
        round(0, 1, 1, "R9 trigger during linger kept");
    endtask

    task automatic test_wrap();
        while (total_pulses < ROWS + 3) round(0, 1, 1, "R8 wrap run");
        chk(exp_row == (total_pulses % ROWS), "R8 row sequence", exp_row, total_pulses % ROWS);
    endtask

    initial begin
        test_reset();
        test_interval();
        test_late_grant();
        test_backlog();
        test_linger();
        test_wrap();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule